// File: doc/BRIEF.md
# Endpoint User-Domain Reset Combiner

This block gathers every condition that must hold a serial-link endpoint's user logic in reset and produces one active-high reset in the user clock domain. The conditions are an asynchronous active-low fundamental reset, covering both cold and warm reset, a lock flag from the core clocking PLL, and one lock flag per transceiver PLL. The block raises the user reset when any of these reports a fault. It lowers the reset only on a user clock edge, and only after every condition has been good for an unbroken, programmable number of cycles. The fundamental reset must stay asserted until the reference clock is stable.

The fundamental reset drives the output flop's asynchronous set directly, so the user reset rises with no clock edge. Lock flags pass through two-stage synchronizers in the user domain before they are used. A settle counter restarts whenever any synchronized source drops. A 2-bit cause register holds the code of the most recent fault source. A clear pulse returns it to zero, but only when no fault is present.

Top module: `rst_release_seq`

## Requirements
- R1: A falling `fund_rst_n` sets `user_rst` to 1 at once, without waiting for a clock edge.
- R2: While `fund_rst_n` is low, `user_rst` stays 1 and `cause` reads 1 from the first clock edge on.
- R3: After `fund_rst_n` rises with all lock flags high, `user_rst` falls on rising edge SETTLE_CYC+3, counting the first edge after the release as edge 1. It then stays low.
- R4: A fall of `core_lock` sets `user_rst` on the third rising edge after the fall.
- R5: A fall of any single bit of `xcvr_lock` sets `user_rst` on the third rising edge after the fall.
- R6: After the last faulty lock flag returns high, `user_rst` falls on rising edge SETTLE_CYC+3, counted from the return.
- R7: A fault of any length that occurs while the settle count runs restarts the count. Release then follows R6, counted from the end of that fault.
- R8: `cause` encodes 0 = none, 1 = fundamental reset, 2 = core PLL, 3 = transceiver PLL. A lock fault sets its code on the same edge that raises `user_rst`. When sources fail together, fundamental beats core, and core beats transceiver. The code is held after all faults clear.
- R9: When `cause_clr` is high at a rising edge and no synchronized fault is present, `cause` becomes 0 on that edge. When a synchronized fault is present at that edge, the clear is ignored and the fault's code is written instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| fund_rst_n | input | 1 | Asynchronous active-low fundamental reset |
| core_lock | input | 1 | Core clocking PLL lock flag, asynchronous |
| xcvr_lock | input | NUM_XCVR | Per-transceiver PLL lock flags, asynchronous |
| cause_clr | input | 1 | Software clear of the cause register, sampled on `clk` |
| user_rst | output | 1 | Active-high user-domain reset |
| cause | output | 2 | Code of the most recent fault source |

## Verification
Two functions can act in the same cycle: a software clear of the cause register, and a new lock fault reaching the synchronizer output. The bench drops a transceiver lock flag and times `cause_clr` to be sampled on exactly the edge where the synchronized fault appears. It then checks that `cause` reads the transceiver code and not zero. A second case is a fault during the settle count. The bench sweeps the position of a one-cycle glitch across the whole count and checks that the release edge always moves to SETTLE_CYC+3 after the glitch ends.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_FUND = 2'd1,
        CAUSE_CORE = 2'd2,
        CAUSE_XCVR = 2'd3
    } cause_e;

    typedef struct packed {
        logic fund_ok;
        logic core_ok;
        logic xcvr_ok;
    } health_t;

    function automatic logic health_good(health_t h);
        return h.fund_ok & h.core_ok & h.xcvr_ok;
    endfunction

    // Priority: fundamental, then core PLL, then transceiver PLL; clear last.
    function automatic cause_e next_cause(health_t h, cause_e cur, logic clr);
        if (!h.fund_ok) return CAUSE_FUND;
        if (!h.core_ok) return CAUSE_CORE;
        if (!h.xcvr_ok) return CAUSE_XCVR;
        if (clr)        return CAUSE_NONE;
        return cur;
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stg <= '0;
        else         stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rst_seq_settle.sv
module rst_seq_settle #(
    parameter int SETTLE_CYC = 16,
    parameter int CNT_W      = $clog2(SETTLE_CYC + 1)
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             ok,
    output logic             settled,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

    assign settled = (cnt == LIMIT);

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)       cnt <= '0;
        else if (!ok)      cnt <= '0;
        else if (!settled) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rst_seq_cause.sv
module rst_seq_cause
    import rst_seq_pkg::*;
(
    input  logic    clk,
    input  health_t hlth,
    input  logic    clr,
    output cause_e  cause
);
    // No reset: a fundamental reset must write its own code here.
    always_ff @(posedge clk) begin
        cause <= next_cause(hlth, cause, clr);
    end
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq
    import rst_seq_pkg::*;
#(
    parameter int NUM_XCVR    = 4,
    parameter int SETTLE_CYC  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                fund_rst_n,
    input  logic                core_lock,
    input  logic [NUM_XCVR-1:0] xcvr_lock,
    input  logic                cause_clr,
    output logic                user_rst,
    output logic [1:0]          cause
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam int LANES = NUM_XCVR + 1;

    logic             fund_s;
    logic [LANES-1:0] lock_s;
    health_t          hlth;
    logic             all_ok;
    logic             settled;
    logic [CNT_W-1:0] cnt;
    cause_e           cause_q;

    rst_seq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_fund_sync (
        .clk    (clk),
        .arst_n (fund_rst_n),
        .d      (1'b1),
        .q      (fund_s)
    );

    rst_seq_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_lock_sync (
        .clk    (clk),
        .arst_n (fund_rst_n),
        .d      ({xcvr_lock, core_lock}),
        .q      (lock_s)
    );

    assign hlth.fund_ok = fund_s;
    assign hlth.core_ok = lock_s[0];
    assign hlth.xcvr_ok = &lock_s[LANES-1:1];
    assign all_ok       = health_good(hlth);

    rst_seq_settle #(.SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)) u_settle (
        .clk     (clk),
        .arst_n  (fund_rst_n),
        .ok      (all_ok),
        .settled (settled),
        .cnt     (cnt)
    );

    rst_seq_cause u_cause (
        .clk   (clk),
        .hlth  (hlth),
        .clr   (cause_clr),
        .cause (cause_q)
    );

    always_ff @(posedge clk or negedge fund_rst_n) begin
        if (!fund_rst_n) user_rst <= 1'b1;
        else             user_rst <= !(all_ok && settled);
    end

    assign cause = cause_q;
endmodule

// File: rtl/rst_release_seq_chk.sv
module rst_release_seq_chk #(
    parameter int SETTLE_CYC = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             fund_rst_n,
    input logic             cause_clr,
    input logic             user_rst,
    input logic [1:0]       cause,
    input logic             all_ok,
    input logic             fund_ok,
    input logic             core_ok,
    input logic             settled,
    input logic [CNT_W-1:0] cnt
);
    p_fund_hold_r1: assert property (@(posedge clk)
        !fund_rst_n |-> user_rst);

    p_fund_cause_r2: assert property (@(posedge clk) disable iff (!fund_rst_n)
        !fund_ok |=> (cause == 2'd1));

    p_release_gate_r3: assert property (@(posedge clk) disable iff (!fund_rst_n)
        $fell(user_rst) |-> ($past(all_ok) && $past(settled)));

    p_fault_sets_r4: assert property (@(posedge clk) disable iff (!fund_rst_n)
        !all_ok |=> user_rst);

    p_cnt_restart_r7: assert property (@(posedge clk) disable iff (!fund_rst_n)
        !all_ok |=> (cnt == '0));

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!fund_rst_n)
        cnt <= CNT_W'(SETTLE_CYC));

    p_core_cause_r8: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (fund_ok && !core_ok) |=> (cause == 2'd2));

    p_clear_r9: assert property (@(posedge clk) disable iff (!fund_rst_n)
        (cause_clr && all_ok) |=> (cause == 2'd0));
endmodule

bind rst_release_seq rst_release_seq_chk #(
    .SETTLE_CYC (SETTLE_CYC),
    .CNT_W      (CNT_W)
) chk_i (
    .clk        (clk),
    .fund_rst_n (fund_rst_n),
    .cause_clr  (cause_clr),
    .user_rst   (user_rst),
    .cause      (cause),
    .all_ok     (all_ok),
    .fund_ok    (hlth.fund_ok),
    .core_ok    (hlth.core_ok),
    .settled    (settled),
    .cnt        (cnt)
);

// File: tb/rst_release_seq_tb_top.sv
`timescale 1ns/1ps
module rst_release_seq_tb_top;
    localparam int NX = 3;
    localparam int ST = 6;

    logic          clk = 1'b0;
    logic          fund_rst_n = 1'b1;
    logic          core_lock = 1'b1;
    logic [NX-1:0] xcvr_lock = '1;
    logic          cause_clr = 1'b0;
    logic          user_rst;
    logic [1:0]    cause;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rst_release_seq #(.NUM_XCVR(NX), .SETTLE_CYC(ST)) dut_i (
        .clk        (clk),
        .fund_rst_n (fund_rst_n),
        .core_lock  (core_lock),
        .xcvr_lock  (xcvr_lock),
        .cause_clr  (cause_clr),
        .user_rst   (user_rst),
        .cause      (cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Call right after the last source was restored at a negedge.
    task automatic expect_release(input string tag);
        repeat (ST + 2) @(posedge clk);
        #1 chk(tag, int'(user_rst), 1);
        @(posedge clk);
        #1 chk(tag, int'(user_rst), 0);
    endtask

    // Call right after a lock flag was dropped at a negedge, reset idle.
    task automatic expect_assert(input string tag);
        repeat (2) @(posedge clk);
        #1 chk(tag, int'(user_rst), 0);
        @(posedge clk);
        #1 chk(tag, int'(user_rst), 1);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        // R1 / R2: power-on fundamental reset
        #1 fund_rst_n = 1'b0;
        #1 chk("R1 async set", int'(user_rst), 1);
        @(posedge clk); #1 chk("R2 cause fund", int'(cause), 1);
        repeat (3) @(posedge clk);
        #1 chk("R2 held", int'(user_rst), 1);

        // R3: release timing
        @(negedge clk) fund_rst_n = 1'b1;
        expect_release("R3 release");
        repeat (4) @(posedge clk);
        #1 chk("R3 stays low", int'(user_rst), 0);
        chk("R8 cause held", int'(cause), 1);

        // R4 / R6: core PLL loss and recovery
        @(negedge clk) core_lock = 1'b0;
        expect_assert("R4 core loss");
        chk("R8 cause core", int'(cause), 2);
        @(negedge clk) core_lock = 1'b1;
        expect_release("R6 core back");

        // R5 / R6 sweep over every transceiver lane
        for (int i = 0; i < NX; i++) begin
            @(negedge clk) xcvr_lock[i] = 1'b0;
            expect_assert("R5 lane loss");
            chk("R8 cause xcvr", int'(cause), 3);
            @(negedge clk) xcvr_lock[i] = 1'b1;
            expect_release("R6 lane back");
        end

        // R9: clear with no fault present
        @(negedge clk) cause_clr = 1'b1;
        @(posedge clk); #1 chk("R9 clear", int'(cause), 0);
        @(negedge clk) cause_clr = 1'b0;

        // R7: glitch at every position of the settle count
        for (int k = 0; k < ST; k++) begin
            @(negedge clk) core_lock = 1'b0;
            @(negedge clk) core_lock = 1'b1;
            repeat (k) @(posedge clk);
            @(negedge clk) xcvr_lock[k % NX] = 1'b0;
            @(negedge clk) xcvr_lock[k % NX] = 1'b1;
            expect_release("R7 restart");
            chk("R8 last cause", int'(cause), 3);
        end

        // R9: clear ignored while a fault is present
        @(negedge clk) core_lock = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) cause_clr = 1'b1;
        @(negedge clk) cause_clr = 1'b0;
        #1 chk("R9 clear ignored", int'(cause), 2);
        @(negedge clk) core_lock = 1'b1;
        expect_release("R6 after clear");

        // R9: clear sampled on the edge where a synchronized fault appears
        @(negedge clk) xcvr_lock[1] = 1'b0;
        @(negedge clk);
        @(negedge clk) cause_clr = 1'b1;
        @(negedge clk) cause_clr = 1'b0;
        #1 chk("R9 clear vs fault", int'(cause), 3);
        chk("R5 coincident", int'(user_rst), 1);
        @(negedge clk) xcvr_lock[1] = 1'b1;
        expect_release("R6 coincident");

        // R8: simultaneous core and transceiver loss -> core wins
        @(negedge clk) begin core_lock = 1'b0; xcvr_lock[2] = 1'b0; end
        expect_assert("R4 dual loss");
        chk("R8 priority", int'(cause), 2);
        @(negedge clk) begin core_lock = 1'b1; xcvr_lock[2] = 1'b1; end
        expect_release("R6 dual back");

        // R1: mid-cycle fundamental reset while a lock is also lost
        @(negedge clk) core_lock = 1'b0;
        #2 fund_rst_n = 1'b0;
        #1 chk("R1 mid-cycle", int'(user_rst), 1);
        @(posedge clk); #1 chk("R8 fund priority", int'(cause), 1);
        @(negedge clk) core_lock = 1'b1;
        @(negedge clk) fund_rst_n = 1'b1;
        expect_release("R3 second release");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end
endmodule